// File: doc/BRIEF.md
# Fractional Oscillator Trim Ditherer

This block sits between an oscillator's trim logic and the oscillator's fine-trim input. It takes three things:

- a coarse range code;
- a fine trim code;
- a signed fractional correction written by software.

On every dither clock it issues a fine trim code. That code is either the current fine setting or the adjacent setting, chosen so that the time average falls between two fine steps. The correction is an 8-bit two's-complement number. Its magnitude is added every cycle into a 7-bit phase accumulator, and each carry out of that accumulator selects the neighbouring code for one cycle. A positive correction pulls the average upward and a negative correction pulls it downward, in steps of 1/128 of a fine step.

The correction register is kept in a small three-state mode controller. The states are:

- `ST_HOLD`: the value is zero and no dither is applied.
- `ST_RAISE`: the value is positive and the neighbour is fine+1.
- `ST_LOWER`: the value is negative and the neighbour is fine-1.

A write of zero takes the controller to `ST_HOLD`. A write of 1..127 takes it to `ST_RAISE`. A write of -128..-1 takes it to `ST_LOWER`. With no write, the controller stays in its state. Every state can reach every other state in a single write.

The coarse and fine codes can be read back on output ports, but this interface cannot write them.

Top module: `osc_trim_dither`

## Requirements
- R1: While reset is asserted and after it is released, before the first active clock edge, `fine_eff`, `sf_rd`, `coarse_rd` and `fine_rd` are all zero.
- R2: When `sf_wr_en` is high at a rising edge, `sf_wr_data` (8-bit two's complement) is stored and appears on `sf_rd` after that edge.
- R3: With a stored correction of zero, `fine_eff` after each edge equals the `fine_in` sampled at that edge.
- R4: With a positive correction P, `fine_eff` is `fine_in` or `fine_in`+1. Over any 128 consecutive edges with constant inputs, exactly P of them give `fine_in`+1.
- R5: With a negative correction N, `fine_eff` is `fine_in` or `fine_in`-1. Over any 128 consecutive edges with constant inputs, exactly |N| of them give `fine_in`-1, and for -128 that is every edge.
- R6: A 7-bit phase accumulator adds |correction| (0..128) on every edge. The adjacent code is used at exactly the edges where the sum reaches 128 or more, and the accumulator keeps the sum modulo 128.
- R7: The output saturates. Raising from 0xFF gives 0xFF, and lowering from 0x00 gives 0x00, never a wrapped code.
- R8: A newly written correction first affects the edge after the write, and a write does not clear the phase accumulator.
- R9: `coarse_rd` and `fine_rd` show `coarse_in` and `fine_in` as sampled at the last edge. Correction writes do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dither clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sf_wr_en | input | 1 | Write strobe for the fractional correction |
| sf_wr_data | input | 8 | Fractional correction, two's complement |
| coarse_in | input | 8 | Current coarse range code |
| fine_in | input | 8 | Current fine trim code |
| sf_rd | output | 8 | Stored fractional correction |
| coarse_rd | output | 8 | Read-back of the coarse range code |
| fine_rd | output | 8 | Read-back of the fine trim code |
| fine_eff | output | 8 | Fine trim code applied this cycle |

## Verification
The hardest condition to reach is a write landing while the phase accumulator holds a nonzero residue. If the block wrongly cleared or restarted the accumulator on a write, the dither pattern would shift, but only by a phase offset that a simple count over a window would not show. The stimulus first runs a correction long enough to leave a known residue. It then writes new values and compares every edge against a bench model of the accumulator. After that, long random stretches with sparse random writes, including -128, zero and the saturating codes 0x00 and 0xFF, keep reaching that condition with varied residues.

// File: rtl/osc_trim_dither_pkg.sv
package osc_trim_dither_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_RAISE = 2'd1,
        ST_LOWER = 2'd2
    } dith_mode_e;

endpackage

// File: rtl/sf_mode_ctrl.sv
module sf_mode_ctrl
    import osc_trim_dither_pkg::*;
#(
    parameter int SF_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [SF_W-1:0] wr_data,
    output logic [SF_W-1:0] sf_q,
    output dith_mode_e      mode,
    output logic [SF_W-1:0] mag
);

    localparam logic [SF_W-1:0] SF_ONE = {{(SF_W-1){1'b0}}, 1'b1};

    dith_mode_e state_q;
    dith_mode_e state_nxt;

    // state register and stored correction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            sf_q    <= '0;
        end else begin
            state_q <= state_nxt;
            if (wr_en) begin
                sf_q <= wr_data;
            end
        end
    end

    // transitions: only a write moves the state
    always_comb begin
        state_nxt = state_q;
        if (wr_en) begin
            if (wr_data == '0) begin
                state_nxt = ST_HOLD;
            end else if (wr_data[SF_W-1]) begin
                state_nxt = ST_LOWER;
            end else begin
                state_nxt = ST_RAISE;
            end
        end
    end

    // outputs: per-state step magnitude
    always_comb begin
        mode = state_q;
        unique case (state_q)
            ST_RAISE: mag = sf_q;
            ST_LOWER: mag = ~sf_q + SF_ONE;
            default:  mag = '0;
        endcase
    end

    AST_HOLD_IFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) == (sf_q == '0)); // R2

    AST_LOWER_IFF_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOWER) == sf_q[SF_W-1]); // R5

endmodule

// File: rtl/phase_acc.sv
module phase_acc #(
    parameter int SF_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SF_W-1:0] mag,
    output logic            carry
);

    localparam int PHASE_W = SF_W - 1;
    localparam logic [SF_W-1:0] FULL_SCALE = {1'b1, {PHASE_W{1'b0}}};

    logic [PHASE_W-1:0] acc_q;
    logic [SF_W-1:0]    sum;

    always_comb begin
        sum   = {1'b0, acc_q} + mag;
        carry = sum[SF_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum[PHASE_W-1:0];
        end
    end

    AST_FULL_SCALE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mag == FULL_SCALE) |-> carry); // R6

    AST_ZERO_STEP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mag == '0) |=> $stable(acc_q)); // R6

endmodule

// File: rtl/fine_select.sv
module fine_select
    import osc_trim_dither_pkg::*;
#(
    parameter int TRIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TRIM_W-1:0] fine_in,
    input  dith_mode_e        mode,
    input  logic              carry,
    output logic [TRIM_W-1:0] fine_eff
);

    localparam logic [TRIM_W-1:0] TRIM_TOP = '1;
    localparam logic [TRIM_W-1:0] TRIM_ONE = {{(TRIM_W-1){1'b0}}, 1'b1};

    logic [TRIM_W-1:0] fine_up;
    logic [TRIM_W-1:0] fine_dn;
    logic [TRIM_W-1:0] fine_nxt;

    always_comb begin
        fine_up = (fine_in == TRIM_TOP) ? fine_in : fine_in + TRIM_ONE;
        fine_dn = (fine_in == '0)       ? fine_in : fine_in - TRIM_ONE;
        unique case (mode)
            ST_RAISE: fine_nxt = carry ? fine_up : fine_in;
            ST_LOWER: fine_nxt = carry ? fine_dn : fine_in;
            default:  fine_nxt = fine_in;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fine_eff <= '0;
        end else begin
            fine_eff <= fine_nxt;
        end
    end

    AST_HOLD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode == ST_HOLD)) |-> (fine_eff == $past(fine_in))); // R3

    AST_RAISE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode == ST_RAISE)) |->
        ((fine_eff == $past(fine_in)) || (fine_eff == $past(fine_in) + TRIM_ONE))); // R4

    AST_LOWER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode == ST_LOWER)) |->
        ((fine_eff == $past(fine_in)) || (fine_eff == $past(fine_in) - TRIM_ONE))); // R5

    AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode == ST_RAISE) && $past(fine_in == TRIM_TOP))
        |-> (fine_eff == TRIM_TOP)); // R7

    AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode == ST_LOWER) && $past(fine_in == '0))
        |-> (fine_eff == '0)); // R7

endmodule

// File: rtl/osc_trim_dither.sv
module osc_trim_dither
    import osc_trim_dither_pkg::*;
#(
    parameter int TRIM_W = 8,
    parameter int SF_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sf_wr_en,
    input  logic [SF_W-1:0]   sf_wr_data,
    input  logic [TRIM_W-1:0] coarse_in,
    input  logic [TRIM_W-1:0] fine_in,
    output logic [SF_W-1:0]   sf_rd,
    output logic [TRIM_W-1:0] coarse_rd,
    output logic [TRIM_W-1:0] fine_rd,
    output logic [TRIM_W-1:0] fine_eff
);

    dith_mode_e      mode;
    logic [SF_W-1:0] mag;
    logic            carry;

    sf_mode_ctrl #(.SF_W(SF_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sf_wr_en),
        .wr_data (sf_wr_data),
        .sf_q    (sf_rd),
        .mode    (mode),
        .mag     (mag)
    );

    phase_acc #(.SF_W(SF_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .mag   (mag),
        .carry (carry)
    );

    fine_select #(.TRIM_W(TRIM_W)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .fine_in  (fine_in),
        .mode     (mode),
        .carry    (carry),
        .fine_eff (fine_eff)
    );

    // read-only view of the trim codes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coarse_rd <= '0;
            fine_rd   <= '0;
        end else begin
            coarse_rd <= coarse_in;
            fine_rd   <= fine_in;
        end
    end

    AST_RDBK_IGNORES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sf_wr_en) && $stable(coarse_in))
        |=> $stable(coarse_rd)); // R9

endmodule

// File: tb/tb_osc_trim_dither.sv
`timescale 1ns/1ps
module tb_osc_trim_dither;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sf_wr_en = 1'b0;
    logic [7:0] sf_wr_data = 8'h00;
    logic [7:0] coarse_in = 8'h00;
    logic [7:0] fine_in = 8'h00;
    logic [7:0] sf_rd, coarse_rd, fine_rd, fine_eff;

    int n_chk = 0;
    int n_fail = 0;

    // bench model state
    logic [7:0] m_sf = 8'h00;
    int         m_acc = 0;
    int         m_eff = 0;
    int         m_crd = 0;
    int         m_frd = 0;

    always #5 clk = ~clk;

    osc_trim_dither dut (
        .clk(clk), .rst_n(rst_n), .sf_wr_en(sf_wr_en), .sf_wr_data(sf_wr_data),
        .coarse_in(coarse_in), .fine_in(fine_in), .sf_rd(sf_rd),
        .coarse_rd(coarse_rd), .fine_rd(fine_rd), .fine_eff(fine_eff)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int step_mag(input logic [7:0] sf);
        return sf[7] ? (256 - int'(sf)) : int'(sf);
    endfunction

    function automatic int pick_code(input logic [7:0] sf, input bit cy, input int f);
        if (!cy || sf == 8'h00) return f;
        if (!sf[7]) return (f == 255) ? 255 : f + 1;
        return (f == 0) ? 0 : f - 1;
    endfunction

    // one dither clock with model update and full output compare
    task automatic tick(input bit we, input logic [7:0] wd, input logic [7:0] c,
                        input logic [7:0] f, input string tag);
        int sum;
        @(negedge clk);
        sf_wr_en = we; sf_wr_data = wd; coarse_in = c; fine_in = f;
        @(posedge clk);
        sum   = m_acc + step_mag(m_sf);
        m_eff = pick_code(m_sf, sum >= 128, int'(f));
        m_acc = sum % 128;
        m_crd = int'(c);
        m_frd = int'(f);
        if (we) m_sf = wd;
        #1;
        chk(tag, int'(fine_eff), m_eff);
        chk("R2 sf_rd", int'(sf_rd), int'(m_sf));
        chk("R9 coarse_rd", int'(coarse_rd), m_crd);
        chk("R9 fine_rd", int'(fine_rd), m_frd);
    endtask

    // run n edges with constant inputs, count edges that gave code tgt
    task automatic window(input int n, input logic [7:0] c, input logic [7:0] f,
                          input int tgt, input string tag, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            tick(1'b0, 8'h00, c, f, tag);
            if (int'(fine_eff) == tgt) hits++;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int hits;
        void'($urandom(32'd20240611));
        #23;
        // R1 reset state
        chk("R1 fine_eff", int'(fine_eff), 0);
        chk("R1 sf_rd", int'(sf_rd), 0);
        chk("R1 coarse_rd", int'(coarse_rd), 0);
        chk("R1 fine_rd", int'(fine_rd), 0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 after release", int'(fine_eff), 0);

        // R3 zero correction passes fine through
        tick(1'b1, 8'h00, 8'h11, 8'h40, "R3");
        for (int i = 0; i < 20; i++) tick(1'b0, 8'h00, 8'h11, 8'(8'h40 + i), "R3");

        // R4 positive: 37 raised edges in 128
        tick(1'b1, 8'd37, 8'h22, 8'h80, "R8 write edge");
        window(128, 8'h22, 8'h80, 8'h81, "R4", hits);
        chk("R4 window count", hits, 37);

        // R8 write with residue in accumulator, new value next edge
        tick(1'b1, 8'd100, 8'h22, 8'h80, "R8 residue write");
        tick(1'b1, 8'hFB, 8'h22, 8'h80, "R8 new value");
        window(128, 8'h33, 8'h80, 8'h7F, "R5", hits);
        chk("R5 window count -5", hits, 5);

        // R5 full negative scale
        tick(1'b1, 8'h80, 8'h33, 8'h10, "R8");
        window(128, 8'h33, 8'h10, 8'h0F, "R5", hits);
        chk("R5 window count -128", hits, 128);

        // R7 saturation both ends
        tick(1'b1, 8'd127, 8'h44, 8'hFF, "R7");
        window(40, 8'h44, 8'hFF, 8'hFF, "R7 top", hits);
        chk("R7 top hold", hits, 40);
        tick(1'b1, 8'h9C, 8'h44, 8'h00, "R7");
        window(40, 8'h44, 8'h00, 8'h00, "R7 bottom", hits);
        chk("R7 bottom hold", hits, 40);

        // R9 writes do not disturb readback
        for (int i = 0; i < 16; i++) tick(1'b1, 8'(i * 17), 8'h5A, 8'hA5, "R9");

        // R6 random with sparse writes and corner codes
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] f;
            logic [7:0] w;
            bit         we;
            int         r;
            r  = int'($urandom_range(0, 9));
            f  = (r == 0) ? 8'h00 : (r == 1) ? 8'hFF : 8'($urandom_range(0, 255));
            we = ($urandom_range(0, 7) == 0);
            r  = int'($urandom_range(0, 7));
            w  = (r == 0) ? 8'h80 : (r == 1) ? 8'h00 : (r == 2) ? 8'h7F
                                 : 8'($urandom_range(0, 255));
            tick(we, w, 8'($urandom_range(0, 255)), f, "R6");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule